// File: doc/BRIEF.md
# Unordered Coalescing Store Cache

This block sits beside one core and holds every store the core makes during the execution phase of an epoch. It takes the place of a first-in first-out store buffer. Entries sit in a set-associative array. Nothing records the program order between entries. A store to a line that is already held merges into that entry, and a per-byte valid mask records which bytes have been written. Loads probe the array in the same cycle and take the buffered bytes when every byte they ask for is held. Stores stay private to the core until the drain phase.

When the core enters the drain phase, the block hands its held lines out on a valid/ready stream in whatever order suits it. It raises `empty` once nothing is left, and the core uses that to decide when to signal its second barrier. A store that misses a full set is handled according to the mode input. In the two implementation-dependent modes, the block refuses the store and raises an epoch-termination request. In the portable mode, it passes the store out to an external log stream and marks the overflow flag of that set. A later load miss to a marked set then asks for a log lookup.

The store, log and drain interfaces are valid/ready streams. A transfer happens on a clock edge where both valid and ready are high. Only the log stream passes back-pressure through: `st_ready` follows `log_ready` while a store is being diverted to the log. The load probe, the mode, the phase, the termination request and the flags are plain pins.

Top module: `coalescing_store_cache`

## Requirements
- R1: After reset the cache holds nothing. `empty` is 1, `dr_valid` is 0, `ovf_flags` is all zero and no load hits.
- R2: A store accepted in the execution phase occupies an entry on the next cycle, which clears `empty`. It does not appear on the drain port while `drain_phase` is 0.
- R3: A store whose line address matches a held entry merges into that entry. The bytes it enables overwrite the older bytes, its mask is ORed into the valid mask, and the line drains as a single beat.
- R4: `ld_hit` is 1 in the same cycle when `ld_valid` is 1, the line is held and every byte set in `ld_mask` is valid. `ld_data` carries the held valid bytes, with the other bytes at zero.
- R5: A load to a held line that asks for any byte not yet written gets `ld_hit` = 0.
- R6: With `mode` 2'b00, 2'b01 or 2'b11, a store that misses a set whose ways are all held gets `st_ready` = 0 and `term_req` = 1, and it is not taken. A store that hits a held line in a full set is still accepted and merged.
- R7: With `mode` 2'b10 (portable), a store that misses a full set is offered on the log stream with its address, data and mask, and `st_ready` follows `log_ready`. On the transfer, the overflow flag of that set is set. The cache contents are left unchanged.
- R8: `ld_log_lookup` is 1 when `ld_valid` is 1, `ld_hit` is 0 and the overflow flag of the load's set is 1. It is 0 otherwise.
- R9: While `drain_phase` is 1, `st_ready` is 0. Each held line is offered exactly once on the drain stream, and `dr_valid` and `dr_addr` hold steady while `dr_ready` is 0. `empty` rises after the last transfer. `dr_valid` is 0 outside the drain phase.
- R10: On the first edge where `drain_phase` and `empty` are both 1, all overflow flags clear.
- R11: The set of a line is the low log2(sets) bits of its line address, so `ovf_flags[i]` belongs to set i. Filling one set has no effect on a store to another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 cycle-bounded, 01 bounded deterministic, 10 portable deterministic, 11 same as 01 |
| drain_phase | input | 1 | 1 during the drain phase of an epoch |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted on this edge |
| st_addr | input | ADDR_W | Store line address |
| st_data | input | LINE_BYTES*8 | Store line data |
| st_mask | input | LINE_BYTES | Store byte enables |
| term_req | output | 1 | Request to end the epoch (full set, non-portable mode) |
| log_valid | output | 1 | Diverted store offered to the log |
| log_ready | input | 1 | Log accepts the store |
| log_addr | output | ADDR_W | Diverted store line address |
| log_data | output | LINE_BYTES*8 | Diverted store data |
| log_mask | output | LINE_BYTES | Diverted store byte enables |
| ld_valid | input | 1 | Load probe valid |
| ld_addr | input | ADDR_W | Load line address |
| ld_mask | input | LINE_BYTES | Bytes the load needs |
| ld_hit | output | 1 | All requested bytes are held |
| ld_data | output | LINE_BYTES*8 | Held valid bytes of the line, zero elsewhere |
| ld_log_lookup | output | 1 | Miss in a set that has overflowed |
| dr_valid | output | 1 | Drain beat valid |
| dr_ready | input | 1 | Drain beat accepted |
| dr_addr | output | ADDR_W | Drained line address |
| dr_data | output | LINE_BYTES*8 | Drained data, invalid bytes zero |
| dr_mask | output | LINE_BYTES | Drained byte valid mask |
| empty | output | 1 | No line held |
| ovf_flags | output | SETS | Per-set overflow flags |

## Verification
The drain-stability property assumes the core keeps `drain_phase` high until `empty` rises. The bench's drain task only lowers it after seeing `empty`, and it toggles `dr_ready` to create stalls. The overflow-flag property relies on the store address holding steady while the log transfer completes. The bench holds every store request for the whole cycle in which it is offered. No store is driven during the drain phase apart from one probe that must be refused.

// File: rtl/scc_pkg.sv
package scc_pkg;
  typedef enum logic [1:0] {
    MODE_CYCLE    = 2'b00,
    MODE_BOUNDED  = 2'b01,
    MODE_PORTABLE = 2'b10,
    MODE_SPARE    = 2'b11
  } scc_mode_e;

  function automatic logic mode_diverts(input logic [1:0] m);
    return m == MODE_PORTABLE;
  endfunction
endpackage

// File: rtl/scc_first_one.sv
// Lowest-index set bit finder.
module scc_first_one #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/scc_way_match.sv
// Tag compare and free-way search across the ways of one set.
module scc_way_match #(
  parameter int WAYS   = 8,
  parameter int ADDR_W = 26,
  parameter int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]   vld,
  input  logic [ADDR_W-1:0] tags [WAYS],
  input  logic [ADDR_W-1:0] key,
  output logic              hit,
  output logic [WAY_W-1:0]  hit_way,
  output logic              has_free,
  output logic [WAY_W-1:0]  free_way
);
  logic [WAYS-1:0] match;

  always_comb begin
    for (int w = 0; w < WAYS; w++) match[w] = vld[w] && (tags[w] == key);
  end

  scc_first_one #(.N(WAYS), .IW(WAY_W)) u_hit (
    .vec(match), .any(hit), .idx(hit_way)
  );

  scc_first_one #(.N(WAYS), .IW(WAY_W)) u_free (
    .vec(~vld), .any(has_free), .idx(free_way)
  );
endmodule

// File: rtl/coalescing_store_cache.sv
module coalescing_store_cache
  import scc_pkg::*;
#(
  parameter int ENTRIES    = 64,
  parameter int WAYS       = 8,
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 26,
  localparam int SETS      = ENTRIES / WAYS,
  localparam int DW        = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            mode,
  input  logic                  drain_phase,
  input  logic                  st_valid,
  output logic                  st_ready,
  input  logic [ADDR_W-1:0]     st_addr,
  input  logic [DW-1:0]         st_data,
  input  logic [LINE_BYTES-1:0] st_mask,
  output logic                  term_req,
  output logic                  log_valid,
  input  logic                  log_ready,
  output logic [ADDR_W-1:0]     log_addr,
  output logic [DW-1:0]         log_data,
  output logic [LINE_BYTES-1:0] log_mask,
  input  logic                  ld_valid,
  input  logic [ADDR_W-1:0]     ld_addr,
  input  logic [LINE_BYTES-1:0] ld_mask,
  output logic                  ld_hit,
  output logic [DW-1:0]         ld_data,
  output logic                  ld_log_lookup,
  output logic                  dr_valid,
  input  logic                  dr_ready,
  output logic [ADDR_W-1:0]     dr_addr,
  output logic [DW-1:0]         dr_data,
  output logic [LINE_BYTES-1:0] dr_mask,
  output logic                  empty,
  output logic [SETS-1:0]       ovf_flags
);
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int IDX_W = SET_W + WAY_W;

  // Entry storage, flat index = {set, way}
  logic [ENTRIES-1:0]    ent_vld;
  logic [ADDR_W-1:0]     ent_addr [ENTRIES];
  logic [DW-1:0]         ent_data [ENTRIES];
  logic [LINE_BYTES-1:0] ent_mask [ENTRIES];
  logic [SETS-1:0]       ovf_q;

  // Store-side set view
  logic [SET_W-1:0]  st_set;
  logic [WAYS-1:0]   st_vld_s;
  logic [ADDR_W-1:0] st_tag_s [WAYS];
  logic              st_hit, st_free;
  logic [WAY_W-1:0]  st_hit_way, st_free_way;

  // Load-side set view
  logic [SET_W-1:0]  ld_set;
  logic [WAYS-1:0]   ld_vld_s;
  logic [ADDR_W-1:0] ld_tag_s [WAYS];
  logic              ld_tag_hit, ld_free_unused;
  logic [WAY_W-1:0]  ld_hit_way, ld_free_way_unused;

  assign st_set = st_addr[SET_W-1:0];
  assign ld_set = ld_addr[SET_W-1:0];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      st_vld_s[w] = ent_vld[{st_set, WAY_W'(w)}];
      st_tag_s[w] = ent_addr[{st_set, WAY_W'(w)}];
      ld_vld_s[w] = ent_vld[{ld_set, WAY_W'(w)}];
      ld_tag_s[w] = ent_addr[{ld_set, WAY_W'(w)}];
    end
  end

  scc_way_match #(.WAYS(WAYS), .ADDR_W(ADDR_W), .WAY_W(WAY_W)) u_st_match (
    .vld(st_vld_s), .tags(st_tag_s), .key(st_addr),
    .hit(st_hit), .hit_way(st_hit_way),
    .has_free(st_free), .free_way(st_free_way)
  );

  scc_way_match #(.WAYS(WAYS), .ADDR_W(ADDR_W), .WAY_W(WAY_W)) u_ld_match (
    .vld(ld_vld_s), .tags(ld_tag_s), .key(ld_addr),
    .hit(ld_tag_hit), .hit_way(ld_hit_way),
    .has_free(ld_free_unused), .free_way(ld_free_way_unused)
  );

  // Store acceptance and overflow handling
  logic             set_full_miss, diverts, st_take;
  logic [IDX_W-1:0] wr_idx;

  assign set_full_miss = !st_hit && !st_free;
  assign diverts       = mode_diverts(mode);
  assign st_ready      = !drain_phase && (!set_full_miss || (diverts && log_ready));
  assign log_valid     = st_valid && !drain_phase && set_full_miss && diverts;
  assign term_req      = st_valid && !drain_phase && set_full_miss && !diverts;
  assign log_addr      = st_addr;
  assign log_data      = st_data;
  assign log_mask      = st_mask;
  assign st_take       = st_valid && st_ready && !set_full_miss;
  assign wr_idx        = {st_set, (st_hit ? st_hit_way : st_free_way)};

  // Drain selection: lowest held entry
  logic             dr_any;
  logic [IDX_W-1:0] dr_idx;
  logic             dr_fire;

  scc_first_one #(.N(ENTRIES), .IW(IDX_W)) u_drain_pick (
    .vec(ent_vld), .any(dr_any), .idx(dr_idx)
  );

  assign dr_valid = drain_phase && dr_any;
  assign dr_fire  = dr_valid && dr_ready;
  assign dr_addr  = ent_addr[dr_idx];
  assign dr_mask  = ent_mask[dr_idx];
  assign empty    = !dr_any;

  // Load probe
  logic [IDX_W-1:0]      ld_idx;
  logic [LINE_BYTES-1:0] ld_held;

  assign ld_idx        = {ld_set, ld_hit_way};
  assign ld_held       = (ld_valid && ld_tag_hit) ? ent_mask[ld_idx] : '0;
  assign ld_hit        = ld_valid && ld_tag_hit && ((ld_held & ld_mask) == ld_mask);
  assign ld_log_lookup = ld_valid && !ld_hit && ovf_q[ld_set];
  assign ovf_flags     = ovf_q;

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    assign dr_data[b*8 +: 8] = dr_mask[b] ? ent_data[dr_idx][b*8 +: 8] : 8'h00;
    assign ld_data[b*8 +: 8] = ld_held[b] ? ent_data[ld_idx][b*8 +: 8] : 8'h00;
  end

  // Control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld <= '0;
      ovf_q   <= '0;
    end else begin
      if (st_take) ent_vld[wr_idx] <= 1'b1;
      if (dr_fire) ent_vld[dr_idx] <= 1'b0;
      if (log_valid && log_ready) ovf_q[st_set] <= 1'b1;
      if (drain_phase && empty) ovf_q <= '0;
    end
  end

  // Line payload, merged byte by byte
  always_ff @(posedge clk) begin
    if (st_take) begin
      ent_addr[wr_idx] <= st_addr;
      ent_mask[wr_idx] <= (st_hit ? ent_mask[wr_idx] : '0) | st_mask;
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (st_mask[b]) ent_data[wr_idx][b*8 +: 8] <= st_data[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/scc_checker.sv
module scc_checker #(
  parameter int SETS   = 8,
  parameter int ADDR_W = 26,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              drain_phase,
  input logic              st_valid,
  input logic              st_ready,
  input logic [SET_W-1:0]  st_set,
  input logic              term_req,
  input logic              log_valid,
  input logic              log_ready,
  input logic              dr_valid,
  input logic              dr_ready,
  input logic [ADDR_W-1:0] dr_addr,
  input logic              empty,
  input logic [SETS-1:0]   ovf_flags
);
  p_store_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && !log_valid |=> !empty);

  p_full_terminates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    term_req |-> (mode != 2'b10) && !st_ready && !log_valid);

  p_log_marks_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid && log_ready |=> ovf_flags[$past(st_set)]);

  p_drain_blocks_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drain_phase |-> !st_ready);

  p_drain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr));

  p_no_drain_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !drain_phase |-> !dr_valid);

  p_flags_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drain_phase && empty |=> ovf_flags == '0);
endmodule

bind coalescing_store_cache scc_checker #(.SETS(SETS), .ADDR_W(ADDR_W)) u_scc_checker (
  .clk(clk), .rst_n(rst_n), .mode(mode), .drain_phase(drain_phase),
  .st_valid(st_valid), .st_ready(st_ready), .st_set(st_addr[SET_W-1:0]),
  .term_req(term_req), .log_valid(log_valid), .log_ready(log_ready),
  .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
  .empty(empty), .ovf_flags(ovf_flags)
);

// File: tb/coalescing_store_cache_test.sv
`timescale 1ns/1ps
module coalescing_store_cache_test;
  localparam int AW = 26, LB = 64, DW = 512, NSETS = 8, NWAYS = 8;

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [LB-1:0] m;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 2'b01;
  logic drain_phase = 0;
  logic st_valid = 0, st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [LB-1:0] st_mask = '0;
  logic term_req, log_valid, log_ready = 0;
  logic [AW-1:0] log_addr;
  logic [DW-1:0] log_data;
  logic [LB-1:0] log_mask;
  logic ld_valid = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [LB-1:0] ld_mask = '0;
  logic ld_hit, ld_log_lookup;
  logic [DW-1:0] ld_data;
  logic dr_valid, dr_ready = 0;
  logic [AW-1:0] dr_addr;
  logic [DW-1:0] dr_data;
  logic [LB-1:0] dr_mask;
  logic empty;
  logic [NSETS-1:0] ovf_flags;

  int total = 0, bad = 0, beats = 0;
  bit done = 0;
  logic [DW-1:0] m_data [logic [AW-1:0]];
  logic [LB-1:0] m_mask [logic [AW-1:0]];
  item_t sb_q[$];

  always #4 clk = ~clk;

  coalescing_store_cache #(.ENTRIES(NSETS*NWAYS), .WAYS(NWAYS), .LINE_BYTES(LB), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .drain_phase(drain_phase),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .st_mask(st_mask), .term_req(term_req), .log_valid(log_valid), .log_ready(log_ready),
    .log_addr(log_addr), .log_data(log_data), .log_mask(log_mask),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_mask(ld_mask), .ld_hit(ld_hit),
    .ld_data(ld_data), .ld_log_lookup(ld_log_lookup),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr), .dr_data(dr_data),
    .dr_mask(dr_mask), .empty(empty), .ovf_flags(ovf_flags)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_line();
    logic [DW-1:0] d;
    for (int i = 0; i < DW/32; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  function automatic logic [DW-1:0] expand(input logic [LB-1:0] m);
    logic [DW-1:0] e;
    for (int b = 0; b < LB; b++) e[b*8 +: 8] = m[b] ? 8'hFF : 8'h00;
    return e;
  endfunction

  function automatic void model_merge(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LB-1:0] m);
    if (!m_mask.exists(a)) begin
      m_mask[a] = '0;
      m_data[a] = '0;
    end
    for (int b = 0; b < LB; b++) if (m[b]) m_data[a][b*8 +: 8] = d[b*8 +: 8];
    m_mask[a] = m_mask[a] | m;
  endfunction

  task automatic drive_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LB-1:0] m,
                             output bit rdy, output bit term, output bit lv);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_data = d; st_mask = m;
    #1;
    rdy = st_ready; term = term_req; lv = log_valid;
    @(negedge clk);
    st_valid = 0;
  endtask

  // Store expected to land in the cache
  task automatic st_cache(input logic [AW-1:0] a, input logic [LB-1:0] m, input string req);
    logic [DW-1:0] d;
    bit rdy, term, lv;
    d = rnd_line();
    drive_store(a, d, m, rdy, term, lv);
    chk(rdy && !term && !lv, req, {61'd0, rdy, term, lv}, 64'd4);
    if (rdy && !lv) model_merge(a, d, m);
  endtask

  task automatic probe(input logic [AW-1:0] a, input logic [LB-1:0] m,
                       output bit hit, output logic [DW-1:0] d, output bit lk);
    @(negedge clk);
    ld_valid = 1; ld_addr = a; ld_mask = m;
    #1;
    hit = ld_hit; d = ld_data; lk = ld_log_lookup;
    @(negedge clk);
    ld_valid = 0;
  endtask

  // Driver: pushes expected lines, runs the drain phase
  task automatic run_drain(input bit stall, input string req);
    int exp_beats, guard;
    bit r;
    foreach (m_mask[a]) sb_q.push_back('{a, m_data[a] & expand(m_mask[a]), m_mask[a]});
    exp_beats = sb_q.size();
    beats = 0;
    @(negedge clk);
    drain_phase = 1; dr_ready = 0;
    st_valid = 1; st_addr = 26'h3FF_0007; st_mask = '1;
    #1;
    chk(!st_ready, "R9 store refused in drain", {63'd0, st_ready}, 64'd0);
    guard = 0;
    r = 0;
    while (!empty && guard < 1000) begin
      @(negedge clk);
      st_valid = 0;
      r = stall ? !r : 1'b1;
      dr_ready = r;
      guard++;
    end
    @(negedge clk);
    st_valid = 0;
    dr_ready = 0;
    chk(beats == exp_beats, req, 64'(beats), 64'(exp_beats));
    chk(sb_q.size() == 0, "R9 all lines drained", 64'(sb_q.size()), 64'd0);
    chk(empty == 1'b1, "R9 empty after drain", {63'd0, empty}, 64'd1);
    chk(ovf_flags == '0, "R10 flags cleared", 64'(ovf_flags), 64'd0);
    drain_phase = 0;
    m_mask.delete();
    m_data.delete();
  endtask

  // Monitor: pops and compares drained lines
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (dr_valid && !drain_phase)
        chk(0, "R9 drain outside phase", 64'd1, 64'd0);
      if (dr_valid && dr_ready) begin
        int hit_i;
        hit_i = -1;
        foreach (sb_q[i]) if (sb_q[i].a == dr_addr) hit_i = i;
        beats++;
        if (hit_i < 0) begin
          chk(0, "R3 unexpected or repeated drain line", 64'(dr_addr), 64'd0);
        end else begin
          chk(dr_mask == sb_q[hit_i].m, "R3 drained mask", dr_mask, sb_q[hit_i].m);
          chk(dr_data == sb_q[hit_i].d, "R3 drained data", dr_data[63:0], sb_q[hit_i].d[63:0]);
          sb_q.delete(hit_i);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit hit, lk, rdy, term, lv;
    logic [DW-1:0] d, exp_d, ld0;
    logic [AW-1:0] a_a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(empty && !dr_valid, "R1 empty after reset", {62'd0, empty, dr_valid}, 64'd2);
    chk(ovf_flags == '0, "R1 flags after reset", 64'(ovf_flags), 64'd0);
    probe(26'h10, 64'h1, hit, d, lk);
    chk(!hit && !lk, "R1 no hit after reset", {62'd0, hit, lk}, 64'd0);

    // R2: store held privately
    mode = 2'b01;
    a_a = 26'h10;
    st_cache(a_a, 64'h0000_0000_0000_00FF, "R2 store accepted");
    chk(!empty && !dr_valid, "R2 held, not drained", {62'd0, empty, dr_valid}, 64'd0);

    // R4: bypass
    probe(a_a, 64'h0F, hit, d, lk);
    exp_d = m_data[a_a] & expand(m_mask[a_a]);
    chk(hit && d == exp_d, "R4 bypass hit", d[63:0], exp_d[63:0]);
    // R5: unwritten byte
    probe(a_a, 64'h100, hit, d, lk);
    chk(!hit, "R5 partial miss", {63'd0, hit}, 64'd0);

    // R3: merge with overlap
    st_cache(a_a, 64'h0000_0000_0000_0FF0, "R3 merge store accepted");
    probe(a_a, 64'hFFF, hit, d, lk);
    exp_d = m_data[a_a] & expand(m_mask[a_a]);
    chk(hit && d == exp_d, "R3 merged bytes", d[63:0], exp_d[63:0]);
    chk(d[95:64] == exp_d[95:64], "R3 merged upper bytes", {32'd0, d[95:64]}, {32'd0, exp_d[95:64]});

    // Fill set 1
    for (int k = 0; k < NWAYS; k++) st_cache(AW'(1 + k*NSETS), 64'hFF00, "R11 fill set one");
    // R6: full set, bounded mode
    drive_store(26'h1 + 26'd64*NSETS, rnd_line(), 64'hFF, rdy, term, lv);
    chk(!rdy && term && !lv, "R6 full set terminates (01)", {61'd0, rdy, term, lv}, 64'd2);
    mode = 2'b00;
    drive_store(26'h1 + 26'd65*NSETS, rnd_line(), 64'hFF, rdy, term, lv);
    chk(!rdy && term && !lv, "R6 full set terminates (00)", {61'd0, rdy, term, lv}, 64'd2);
    probe(26'h1 + 26'd65*NSETS, 64'hFF, hit, d, lk);
    chk(!hit, "R6 refused store not held", {63'd0, hit}, 64'd0);
    mode = 2'b11;
    st_cache(26'h1 + 26'd3*NSETS, 64'h3, "R6 hit in full set merges");
    // R11: other set unaffected
    st_cache(26'h2, 64'h1, "R11 other set accepts");

    // R7: portable mode divert
    mode = 2'b10;
    log_ready = 0;
    ld0 = rnd_line();
    @(negedge clk);
    st_valid = 1; st_addr = 26'h1 + 26'd70*NSETS; st_data = ld0; st_mask = 64'hF0;
    #1;
    chk(log_valid && !st_ready && !term_req, "R7 log offered, waits",
        {61'd0, log_valid, st_ready, term_req}, 64'd4);
    chk(log_addr == st_addr && log_mask == st_mask && log_data == ld0, "R7 log payload",
        64'(log_addr), 64'(st_addr));
    @(negedge clk);
    log_ready = 1;
    #1;
    chk(st_ready, "R7 ready follows log", {63'd0, st_ready}, 64'd1);
    @(negedge clk);
    st_valid = 0; log_ready = 0;
    chk(ovf_flags == 8'h02, "R7 flag of set one", 64'(ovf_flags), 64'h02);
    probe(26'h1 + 26'd70*NSETS, 64'hF0, hit, d, lk);
    chk(!hit, "R7 diverted store not cached", {63'd0, hit}, 64'd0);
    // R8
    chk(lk, "R8 lookup on flagged miss", {63'd0, lk}, 64'd1);
    probe(26'h1 + 26'd2*NSETS, 64'h100, hit, d, lk);
    chk(hit && !lk, "R8 no lookup on hit", {62'd0, hit, lk}, 64'd2);
    probe(26'h3 + 26'd9*NSETS, 64'h1, hit, d, lk);
    chk(!hit && !lk, "R8 no lookup in clean set", {62'd0, hit, lk}, 64'd0);

    // R9/R10: drain with back-pressure
    run_drain(1'b1, "R9 one beat per held line (stalled)");

    // Second epoch, free-flowing drain
    mode = 2'b01;
    st_cache(26'h55, 64'hF, "R2 new epoch store");
    st_cache(26'h55, 64'hF0, "R3 new epoch merge");
    st_cache(26'h56, '1, "R2 full line store");
    probe(26'h56, '1, hit, d, lk);
    exp_d = m_data[26'h56];
    chk(hit && d == exp_d, "R4 full-line bypass", d[63:0], exp_d[63:0]);
    run_drain(1'b0, "R9 one beat per held line");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule